// File: doc/BRIEF.md
# Two-Stage Pixel Enable Divider

This block turns a fast source clock into a sparse stream of single-cycle pixel enables. A counter first divides the source by an integer N and gives one intermediate pulse every N cycles. A second stage then drops a programmable share of those intermediate pulses. The share is F/4096, where F is a 12-bit value. The average pixel rate is therefore source / N × (1 − F/4096). Which pulses are dropped follows a fixed, repeatable pattern.

The whole setting comes from one 32-bit configuration word, written with a single strobe. A new word does not act at once. It is held back until the integer counter reaches the end of its current period, so no shortened or stretched period ever appears on the output. The source-select bit is only stored and reported; this block does not switch any clock.

Top module: `fdiv_top`

## Requirements
- R1: With an applied divisor N ≥ 2 and F = 0, `mid_en_o` pulses for exactly one cycle every N source cycles.
- R2: `pix_en_o` is high only in a cycle where `mid_en_o` is also high.
- R3: The fractional stage starts from zero whenever a new configuration is applied. Intermediate pulse number k (counting from 1) is then dropped exactly when k·F/4096 reaches a new integer. Over the first M pulses, M − floor(M·F/4096) pixel enables pass. For F = 2048, pulses alternate pass, drop, pass, and so on.
- R4: When F = 0, every intermediate pulse is passed as a pixel enable.
- R5: A written divisor of 0 or 1 is replaced by 2, giving a period of 2 cycles.
- R6: Word layout: bit 31 is the source select, bits 27:16 hold F, and bits 15:0 hold N. Bits 30:28 have no effect on any output.
- R7: A write takes effect at the first terminal count of the integer stage that follows the write. Until then, the previous period and the previous `src_sel_o` remain in force.
- R8: After reset the block runs with N = 2, F = 0 and source select 0. The counter starts at zero, so the first `mid_en_o` comes in the second cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 32 | Configuration word (see R6) |
| mid_en_o | output | 1 | Intermediate pulse after integer division |
| pix_en_o | output | 1 | Pixel enable after fractional removal |
| src_sel_o | output | 1 | Source select bit currently in force |

## Verification
The integer stage is driven with several divisors, including the clamped values 0 and 1. For each one the spacing of intermediate pulses is measured, which separates a correct terminal count from an off-by-one count. Fractions of 0, 1024, 2048 and 4095 are applied from a fresh accumulator. The pass counts and, for the half-rate setting, the exact pass/drop order show whether the overflow test, the accumulator width and the restart on reconfiguration are right. A write placed in the middle of a long period shows whether the update waits for the terminal count. A word with the reserved bits set shows whether those bits leak into the divisor or the fraction.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
   // Register word layout and reset defaults shared by all pieces.
   localparam int FDIV_CFG_W    = 32;
   localparam int FDIV_SEL_BIT  = 31;
   localparam int FDIV_FRAC_LSB = 16;
   localparam int FDIV_FRAC_W   = 12;
   localparam int FDIV_DIV_W    = 16;
   localparam int FDIV_MIN_DIV  = 2;
   localparam int FDIV_RST_DIV  = 2;
endpackage

// File: rtl/fdiv_cfg_hold.sv
module fdiv_cfg_hold #(
   parameter int DIV_W   = 16,
   parameter int FRAC_W  = 12,
   parameter int MIN_DIV = 2,
   parameter int RST_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              wr_sel_i,
   input  logic [FRAC_W-1:0] wr_frac_i,
   input  logic [DIV_W-1:0]  wr_div_i,
   input  logic              tc_i,
   output logic              sel_o,
   output logic [FRAC_W-1:0] frac_o,
   output logic [DIV_W-1:0]  div_o,
   output logic              load_o
);
   localparam logic [DIV_W-1:0] MIN_D = DIV_W'(MIN_DIV);
   localparam logic [DIV_W-1:0] RST_D = DIV_W'(RST_DIV);

   logic [DIV_W-1:0]  div_lim;
   logic              pend_v;
   logic              pend_sel;
   logic [FRAC_W-1:0] pend_frac;
   logic [DIV_W-1:0]  pend_div;

   generate
      if (MIN_DIV > 1) begin : g_clamp
         assign div_lim = (wr_div_i < MIN_D) ? MIN_D : wr_div_i;
      end else begin : g_raw
         assign div_lim = wr_div_i;
      end
   endgenerate

   assign load_o = tc_i & pend_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_sel  <= 1'b0;
         pend_frac <= '0;
         pend_div  <= RST_D;
      end else begin
         if (wr_i) begin
            pend_sel  <= wr_sel_i;
            pend_frac <= wr_frac_i;
            pend_div  <= div_lim;
         end
         if (wr_i)
            pend_v <= 1'b1;
         else if (tc_i)
            pend_v <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_o  <= 1'b0;
         frac_o <= '0;
         div_o  <= RST_D;
      end else if (load_o) begin
         sel_o  <= pend_sel;
         frac_o <= pend_frac;
         div_o  <= pend_div;
      end
   end
endmodule

// File: rtl/fdiv_int_stage.sv
module fdiv_int_stage #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             tc_o
);
   logic [DIV_W-1:0] cnt;

   assign tc_o = (cnt == (div_i - DIV_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (tc_o)
         cnt <= '0;
      else
         cnt <= cnt + DIV_W'(1);
   end
endmodule

// File: rtl/fdiv_frac_stage.sv
module fdiv_frac_stage #(
   parameter int FRAC_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              clear_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic              pass_o
);
   logic [FRAC_W-1:0] acc;
   logic [FRAC_W:0]   sum;

   assign sum    = {1'b0, acc} + {1'b0, frac_i};
   assign pass_o = ~sum[FRAC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (step_i)
         acc <= clear_i ? '0 : sum[FRAC_W-1:0];
   end
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top #(
   parameter int CFG_W    = fdiv_pkg::FDIV_CFG_W,
   parameter int SEL_BIT  = fdiv_pkg::FDIV_SEL_BIT,
   parameter int FRAC_LSB = fdiv_pkg::FDIV_FRAC_LSB,
   parameter int FRAC_W   = fdiv_pkg::FDIV_FRAC_W,
   parameter int DIV_W    = fdiv_pkg::FDIV_DIV_W,
   parameter int MIN_DIV  = fdiv_pkg::FDIV_MIN_DIV,
   parameter int RST_DIV  = fdiv_pkg::FDIV_RST_DIV
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_i,
   input  logic [CFG_W-1:0] cfg_wdata_i,
   output logic             mid_en_o,
   output logic             pix_en_o,
   output logic             src_sel_o
);
   localparam int FRAC_MSB = FRAC_LSB + FRAC_W - 1;

   generate
      if (DIV_W > FRAC_LSB || FRAC_MSB >= SEL_BIT || SEL_BIT >= CFG_W) begin : g_bad_layout
         $error("fdiv_top: configuration fields overlap or exceed the word");
      end
      if (MIN_DIV < 2 || RST_DIV < MIN_DIV) begin : g_bad_div
         $error("fdiv_top: divisor floor must be at least 2");
      end
   endgenerate

   logic              tc;
   logic              load;
   logic              pass;
   logic [DIV_W-1:0]  div_act;
   logic [FRAC_W-1:0] frac_act;

   fdiv_cfg_hold #(
      .DIV_W(DIV_W), .FRAC_W(FRAC_W), .MIN_DIV(MIN_DIV), .RST_DIV(RST_DIV)
   ) cfg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (cfg_wr_i),
      .wr_sel_i (cfg_wdata_i[SEL_BIT]),
      .wr_frac_i(cfg_wdata_i[FRAC_MSB:FRAC_LSB]),
      .wr_div_i (cfg_wdata_i[DIV_W-1:0]),
      .tc_i     (tc),
      .sel_o    (src_sel_o),
      .frac_o   (frac_act),
      .div_o    (div_act),
      .load_o   (load)
   );

   fdiv_int_stage #(.DIV_W(DIV_W)) int_i (
      .clk  (clk),
      .rst_n(rst_n),
      .div_i(div_act),
      .tc_o (tc)
   );

   fdiv_frac_stage #(.FRAC_W(FRAC_W)) frac_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (tc),
      .clear_i(load),
      .frac_i (frac_act),
      .pass_o (pass)
   );

   assign mid_en_o = tc;
   assign pix_en_o = tc & pass;
endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk #(
   parameter int DIV_W   = 16,
   parameter int FRAC_W  = 12,
   parameter int MIN_DIV = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mid_en_o,
   input logic              pix_en_o,
   input logic              src_sel_o,
   input logic [DIV_W-1:0]  div_act,
   input logic [FRAC_W-1:0] frac_act
);
   // R5
   div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_act >= DIV_W'(MIN_DIV));

   // R2
   pix_in_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en_o |-> mid_en_o);

   // R1
   mid_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mid_en_o |=> !mid_en_o);

   // R4
   zero_frac_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_en_o && frac_act == '0) |-> pix_en_o);

   // R7
   sel_at_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(src_sel_o) |-> $past(mid_en_o));

   // R7
   div_at_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_act) |-> $past(mid_en_o));
endmodule

bind fdiv_top fdiv_chk #(
   .DIV_W(DIV_W), .FRAC_W(FRAC_W), .MIN_DIV(MIN_DIV)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .mid_en_o (mid_en_o),
   .pix_en_o (pix_en_o),
   .src_sel_o(src_sel_o),
   .div_act  (div_act),
   .frac_act (frac_act)
);

// File: tb/fdiv_top_tb_top.sv
module fdiv_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_i = 1'b0;
   logic [31:0] cfg_wdata_i = '0;
   logic        mid_en_o, pix_en_o, src_sel_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fdiv_top dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
      .mid_en_o(mid_en_o), .pix_en_o(pix_en_o), .src_sel_o(src_sel_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit sel, input logic [2:0] rsv,
                                      input int f, input int d);
      return {sel, rsv, 12'(f), 16'(d)};
   endfunction

   // Write a word and return on the negedge of the terminal count that applies it.
   task automatic write_cfg(input logic [31:0] w);
      @(negedge clk);
      cfg_wr_i = 1'b1;
      cfg_wdata_i = w;
      @(negedge clk);
      cfg_wr_i = 1'b0;
      while (!mid_en_o) @(negedge clk);
   endtask

   task automatic measure(input int cyc, output int mids, output int pixs,
                          output int gmin, output int gmax);
      int last = -1;
      mids = 0; pixs = 0; gmin = 1 << 30; gmax = 0;
      for (int i = 1; i <= cyc; i++) begin
         @(negedge clk);
         if (mid_en_o) begin
            mids++;
            if (last >= 0) begin
               if (i - last < gmin) gmin = i - last;
               if (i - last > gmax) gmax = i - last;
            end
            last = i;
         end
         if (pix_en_o) pixs++;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check(mid_en_o == 1'b0, "R8 first cycle mid", int'(mid_en_o), 0);
      check(src_sel_o == 1'b0, "R8 reset select", int'(src_sel_o), 0);
      @(negedge clk);
      check(mid_en_o == 1'b1, "R8 second cycle mid", int'(mid_en_o), 1);
      check(pix_en_o == 1'b1, "R8 reset fraction zero", int'(pix_en_o), 1);
   endtask

   task automatic t_int_div();
      int m, p, gmin, gmax;
      write_cfg(mk(1'b0, 3'd0, 0, 5));
      measure(200, m, p, gmin, gmax);
      check(m == 40, "R1 mid count N=5", m, 40);
      check(gmin == 5 && gmax == 5, "R1 spacing N=5", gmax, 5);
      check(p == m, "R4 all pass F=0", p, m);
   endtask

   task automatic t_clamp();
      int m, p, gmin, gmax;
      write_cfg(mk(1'b0, 3'd0, 0, 1));
      measure(100, m, p, gmin, gmax);
      check(m == 50 && gmax == 2, "R5 divisor 1 forced to 2", m, 50);
      write_cfg(mk(1'b0, 3'd0, 0, 0));
      measure(100, m, p, gmin, gmax);
      check(m == 50 && gmin == 2 && gmax == 2, "R5 divisor 0 forced to 2", gmax, 2);
   endtask

   task automatic t_fracs();
      int m, p, gmin, gmax;
      write_cfg(mk(1'b0, 3'd0, 1024, 3));
      measure(1200, m, p, gmin, gmax);
      check(m == 400, "R1 mid count N=3", m, 400);
      check(p == 300, "R3 quarter removal", p, 300);
      write_cfg(mk(1'b0, 3'd0, 4095, 2));
      measure(128, m, p, gmin, gmax);
      check(p == 1, "R3 near-full removal", p, 1);
   endtask

   task automatic t_half_pattern();
      int k = 0;
      write_cfg(mk(1'b0, 3'd0, 2048, 4));
      while (k < 6) begin
         @(negedge clk);
         if (mid_en_o) begin
            k++;
            check(pix_en_o == bit'(k % 2), "R3 alternating pattern", int'(pix_en_o), k % 2);
         end
      end
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (pix_en_o && !mid_en_o)
            check(1'b0, "R2 pix without mid", 1, 0);
      end
      check(1'b1, "R2 pix only with mid", 1, 1);
   endtask

   task automatic t_reserved();
      int m, p, gmin, gmax;
      write_cfg(mk(1'b0, 3'b111, 0, 6));
      measure(120, m, p, gmin, gmax);
      check(m == 20 && gmax == 6, "R6 reserved bits ignored divisor", gmax, 6);
      check(p == 20, "R6 reserved bits ignored fraction", p, 20);
      check(src_sel_o == 1'b0, "R6 reserved bits ignored select", int'(src_sel_o), 0);
   endtask

   task automatic t_defer();
      int n = 0;
      int m, p, gmin, gmax;
      write_cfg(mk(1'b0, 3'd0, 0, 40));
      repeat (5) @(negedge clk);
      cfg_wr_i = 1'b1;
      cfg_wdata_i = mk(1'b1, 3'd0, 0, 3);
      @(negedge clk);
      cfg_wr_i = 1'b0;
      check(src_sel_o == 1'b0, "R7 select held before terminal count", int'(src_sel_o), 0);
      n = 6;
      while (!mid_en_o) begin
         @(negedge clk);
         n++;
      end
      check(n == 40, "R7 old period completes", n, 40);
      @(negedge clk);
      check(src_sel_o == 1'b1, "R7 select applied at terminal count", int'(src_sel_o), 1);
      measure(29, m, p, gmin, gmax);
      check(m == 10 && gmax == 3, "R7 new period applied", m, 10);
   endtask

   initial begin
      #2_000_000ns;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_int_div();
      t_clamp();
      t_fracs();
      t_half_pattern();
      t_reserved();
      t_defer();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule